// File: doc/BRIEF.md
# Right-Justified Stereo Serial Audio Receiver

This block turns a three-wire stereo audio stream (bit clock, word-select, serial data) into parallel 18-bit two's complement samples. It runs on a fast system clock and oversamples the three lines. A rising edge of the bit clock marks the instant at which the data and word-select levels are taken. Every word-select period holds exactly 48 bit clocks and is split into two halves of 24 clocks. Word-select high carries the left word and low carries the right word. Each sample sits right-justified at the tail of its half, most significant bit first.

A half frame ends when the sampled word-select level changes. At that point the bit count is checked. A half of the right length hands its last 18 bits to the pair stage. A half of any other length raises a one-cycle error flag and is discarded, together with the stereo pair it belongs to. Once a right word completes behind a good left word, both samples are updated together and a one-cycle valid strobe is issued. Words are therefore delivered once per word-select period.

Top module: `jseq_audio_rx`

## Requirements
- R1: While reset is asserted and after its release, `left_o` and `right_o` are zero and `pair_valid_o` and `len_err_o` are low until a complete pair or a bad half frame is received.
- R2: Of each 24-bit half frame, only the final 18 bits form the sample, read most significant bit first. The 6 leading bits have no effect on either output.
- R3: A half frame sampled with word-select at 1 is the left word and goes to `left_o`. A half frame sampled with word-select at 0 is the right word and goes to `right_o`.
- R4: When a right word of correct length ends (word-select sampled going 0 to 1) and the left word in front of it was also correct, `pair_valid_o` pulses for exactly one clock. Both outputs change only in that cycle.
- R5: A half frame whose count of sampled bit-clock edges differs from 24 makes `len_err_o` pulse for one clock. No pair containing it is issued, `left_o` and `right_o` keep their previous values, and the next well-formed frame is delivered normally.
- R6: After reset, bits are not counted until the first word-select change is sampled. The partial half frame before that change raises neither valid nor error.
- R7: Data and word-select are taken only at rising bit-clock edges. Changes to the data line while the bit clock is high have no effect.
- R8: `pair_valid_o` and `len_err_o` are never high in the same cycle, and either one rises only two system clocks after a detected rising bit-clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_i | input | 1 | Serial bit clock, sampled on its rising edge |
| wsel_i | input | 1 | Word-select: 1 left, 0 right |
| sdata_i | input | 1 | Serial data, MSB first, right-justified |
| left_o | output | 18 | Last delivered left sample |
| right_o | output | 18 | Last delivered right sample |
| pair_valid_o | output | 1 | One-cycle strobe when a new pair is presented |
| len_err_o | output | 1 | One-cycle strobe on a half frame of wrong length |

## Verification
The closing of one half frame (length check and word hand-off) and the opening of the next one (count restart and first shift) land on the same bit-clock edge. A length error on a right word coincides with the start of the following left word. The bench drives frames back to back with no gap and mixes in halves of 22, 23 and 25 bits. It judges the outcome from the valid and error counts, and from held sample values, after each following frame. This shows that a bad half is dropped while the next frame's first bit is still counted.

// File: rtl/jseq_rx_pkg.sv
package jseq_rx_pkg;

    typedef enum logic [1:0] {
        AL_IDLE = 2'd0,
        AL_HUNT = 2'd1,
        AL_RUN  = 2'd2
    } align_e;

    typedef enum logic {
        CH_RIGHT = 1'b0,
        CH_LEFT  = 1'b1
    } chan_e;

endpackage

// File: rtl/jseq_rx_sync.sv
module jseq_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_i,
    input  logic wsel_i,
    input  logic sdata_i,
    output logic bit_stb_o,
    output logic wsel_o,
    output logic sdata_o
);
    typedef struct packed {
        logic [STAGES-1:0] ck;
        logic [STAGES-1:0] ws;
        logic [STAGES-1:0] sd;
        logic              ck_prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d         = sync_q;
        sync_d.ck      = {sync_q.ck[STAGES-2:0], bclk_i};
        sync_d.ws      = {sync_q.ws[STAGES-2:0], wsel_i};
        sync_d.sd      = {sync_q.sd[STAGES-2:0], sdata_i};
        sync_d.ck_prev = sync_q.ck[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign bit_stb_o = sync_q.ck[STAGES-1] & ~sync_q.ck_prev;
    assign wsel_o    = sync_q.ws[STAGES-1];
    assign sdata_o   = sync_q.sd[STAGES-1];
endmodule

// File: rtl/jseq_rx_frame.sv
module jseq_rx_frame
    import jseq_rx_pkg::*;
#(
    parameter int SAMPLE_W  = 18,
    parameter int HALF_BITS = 24,
    parameter int CNT_W     = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_stb_i,
    input  logic                wsel_i,
    input  logic                sdata_i,
    output logic                word_stb_o,
    output chan_e               word_ch_o,
    output logic [SAMPLE_W-1:0] word_o,
    output logic                len_err_o
);
    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_GOOD = CNT_W'(HALF_BITS);

    typedef struct packed {
        align_e              st;
        logic                ws_prev;
        logic [CNT_W-1:0]    cnt;
        logic [SAMPLE_W-1:0] sh;
        logic                word_stb;
        chan_e               word_ch;
        logic [SAMPLE_W-1:0] word;
        logic                len_err;
    } frm_t;

    frm_t frm_d, frm_q;

    always_comb begin
        frm_d          = frm_q;
        frm_d.word_stb = 1'b0;
        frm_d.len_err  = 1'b0;
        if (bit_stb_i) begin
            frm_d.sh = {frm_q.sh[SAMPLE_W-2:0], sdata_i};
            unique case (frm_q.st)
                AL_IDLE: begin
                    frm_d.ws_prev = wsel_i;
                    frm_d.st      = AL_HUNT;
                end
                AL_HUNT: begin
                    if (wsel_i != frm_q.ws_prev) begin
                        frm_d.st  = AL_RUN;
                        frm_d.cnt = CNT_W'(1);
                    end
                    frm_d.ws_prev = wsel_i;
                end
                default: begin
                    if (wsel_i != frm_q.ws_prev) begin
                        if (frm_q.cnt == CNT_GOOD) begin
                            frm_d.word_stb = 1'b1;
                            frm_d.word_ch  = chan_e'(frm_q.ws_prev);
                            frm_d.word     = frm_q.sh;
                        end else begin
                            frm_d.len_err  = 1'b1;
                        end
                        frm_d.cnt = CNT_W'(1);
                    end else if (frm_q.cnt != CNT_MAX) begin
                        frm_d.cnt = frm_q.cnt + 1'b1;
                    end
                    frm_d.ws_prev = wsel_i;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) frm_q <= '0;
        else        frm_q <= frm_d;
    end

    assign word_stb_o = frm_q.word_stb;
    assign word_ch_o  = frm_q.word_ch;
    assign word_o     = frm_q.word;
    assign len_err_o  = frm_q.len_err;
endmodule

// File: rtl/jseq_rx_pair.sv
module jseq_rx_pair
    import jseq_rx_pkg::*;
#(
    parameter int SAMPLE_W = 18
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                word_stb_i,
    input  chan_e               word_ch_i,
    input  logic [SAMPLE_W-1:0] word_i,
    input  logic                len_err_i,
    output logic [SAMPLE_W-1:0] left_o,
    output logic [SAMPLE_W-1:0] right_o,
    output logic                valid_o,
    output logic                err_o
);
    typedef struct packed {
        logic [SAMPLE_W-1:0] left_hold;
        logic                left_ok;
        logic [SAMPLE_W-1:0] left;
        logic [SAMPLE_W-1:0] right;
        logic                valid;
        logic                err;
    } pair_t;

    pair_t pair_d, pair_q;

    always_comb begin
        pair_d       = pair_q;
        pair_d.valid = 1'b0;
        pair_d.err   = 1'b0;
        if (len_err_i) begin
            pair_d.err     = 1'b1;
            pair_d.left_ok = 1'b0;
        end else if (word_stb_i) begin
            if (word_ch_i == CH_LEFT) begin
                pair_d.left_hold = word_i;
                pair_d.left_ok   = 1'b1;
            end else begin
                if (pair_q.left_ok) begin
                    pair_d.left  = pair_q.left_hold;
                    pair_d.right = word_i;
                    pair_d.valid = 1'b1;
                end
                pair_d.left_ok = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pair_q <= '0;
        else        pair_q <= pair_d;
    end

    assign left_o  = pair_q.left;
    assign right_o = pair_q.right;
    assign valid_o = pair_q.valid;
    assign err_o   = pair_q.err;
endmodule

// File: rtl/jseq_audio_rx.sv
module jseq_audio_rx
    import jseq_rx_pkg::*;
#(
    parameter int SAMPLE_W    = 18,
    parameter int HALF_BITS   = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bclk_i,
    input  logic                wsel_i,
    input  logic                sdata_i,
    output logic [SAMPLE_W-1:0] left_o,
    output logic [SAMPLE_W-1:0] right_o,
    output logic                pair_valid_o,
    output logic                len_err_o
);
    localparam int CNT_W = $clog2(2 * HALF_BITS + 1);

    logic                bit_stb;
    logic                ws_s;
    logic                sd_s;
    logic                word_stb;
    chan_e               word_ch;
    logic [SAMPLE_W-1:0] word;
    logic                frm_err;

    jseq_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk_i    (bclk_i),
        .wsel_i    (wsel_i),
        .sdata_i   (sdata_i),
        .bit_stb_o (bit_stb),
        .wsel_o    (ws_s),
        .sdata_o   (sd_s)
    );

    jseq_rx_frame #(
        .SAMPLE_W (SAMPLE_W),
        .HALF_BITS(HALF_BITS),
        .CNT_W    (CNT_W)
    ) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_stb_i  (bit_stb),
        .wsel_i     (ws_s),
        .sdata_i    (sd_s),
        .word_stb_o (word_stb),
        .word_ch_o  (word_ch),
        .word_o     (word),
        .len_err_o  (frm_err)
    );

    jseq_rx_pair #(.SAMPLE_W(SAMPLE_W)) u_pair (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_stb_i (word_stb),
        .word_ch_i  (word_ch),
        .word_i     (word),
        .len_err_i  (frm_err),
        .left_o     (left_o),
        .right_o    (right_o),
        .valid_o    (pair_valid_o),
        .err_o      (len_err_o)
    );
endmodule

// File: rtl/jseq_audio_rx_chk.sv
module jseq_audio_rx_chk #(
    parameter int SAMPLE_W = 18
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bit_stb,
    input logic [SAMPLE_W-1:0] left_o,
    input logic [SAMPLE_W-1:0] right_o,
    input logic                pair_valid_o,
    input logic                len_err_o
);
    // R4: the pair strobe lasts a single cycle
    a_r4_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid_o |=> !pair_valid_o);

    // R4: the samples move only together with the strobe
    a_r4_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_valid_o |-> ($stable(left_o) && $stable(right_o)));

    // R5: the error strobe lasts a single cycle
    a_r5_err_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        len_err_o |=> !len_err_o);

    // R8: valid and error exclude each other
    a_r8_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(pair_valid_o && len_err_o));

    // R8: any strobe follows a detected bit-clock rise by two cycles
    a_r8_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_valid_o || len_err_o) |-> $past(bit_stb, 2));
endmodule

bind jseq_audio_rx jseq_audio_rx_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_stb      (bit_stb),
    .left_o       (left_o),
    .right_o      (right_o),
    .pair_valid_o (pair_valid_o),
    .len_err_o    (len_err_o)
);

// File: tb/sim_jseq_audio_rx.sv
module sim_jseq_audio_rx;
    localparam int W = 18;
    localparam int HB = 24;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bclk = 1'b0;
    logic         wsel = 1'b0;
    logic         sdata = 1'b0;
    logic [W-1:0] left_o, right_o;
    logic         pair_valid_o, len_err_o;

    int n_chk = 0, n_fail = 0;
    int n_valid = 0, n_err = 0;
    int exp_valid = 0, exp_err = 0;
    logic [W-1:0] exp_l = '0, exp_r = '0;
    logic         have_prev = 1'b0;
    logic [W-1:0] prev_l, prev_r;
    int           prev_nl, prev_nr;

    always #2 clk = ~clk;

    jseq_audio_rx u0 (
        .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .wsel_i(wsel), .sdata_i(sdata),
        .left_o(left_o), .right_o(right_o),
        .pair_valid_o(pair_valid_o), .len_err_o(len_err_o)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (pair_valid_o) n_valid++;
            if (len_err_o)    n_err++;
        end
    end

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // data set while the bit clock is low; a wrong value is forced during the high phase (R7)
    task automatic send_bit(input logic w, input logic b);
        @(negedge clk);
        bclk = 1'b0; wsel = w; sdata = b;
        repeat (3) @(negedge clk);
        bclk = 1'b1;
        repeat (2) @(negedge clk);
        sdata = ~b;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_half(input logic w, input logic [W-1:0] v, input int n, input int junk);
        for (int i = 0; i < n; i++) begin
            logic b;
            if (i >= n - W) b = v[n-1-i];
            else            b = junk[i % 6];
            send_bit(w, b);
        end
    endtask

    task automatic run_frame(input logic [W-1:0] l, input logic [W-1:0] r,
                             input int nl, input int nr, input int junk);
        send_half(1'b1, l, nl, junk);
        send_half(1'b0, r, nr, ~junk);
        repeat (4) @(negedge clk);
        if (have_prev) begin
            if (prev_nr != HB) exp_err++;
            else if (prev_nl == HB) begin
                exp_valid++; exp_l = prev_l; exp_r = prev_r;
            end
        end
        if (nl != HB) exp_err++;
        check("R4 pair count", n_valid, exp_valid);
        check("R5 error count", n_err, exp_err);
        check("R2 R3 left sample", left_o, exp_l);
        check("R2 R3 right sample", right_o, exp_r);
        have_prev = 1'b1;
        prev_l = l; prev_r = r; prev_nl = nl; prev_nr = nr;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1: reset state
        check("R1 left", left_o, 0);
        check("R1 right", right_o, 0);
        check("R1 valid", pair_valid_o, 0);
        check("R1 err", len_err_o, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 after release", {pair_valid_o, len_err_o}, 0);

        // R6: partial right half before first word-select change
        send_half(1'b0, 18'h155AA, 11, 6'h2A);
        check("R6 no strobe in partial", n_valid + n_err, 0);
        run_frame(18'h1ABCD, 18'h20001, HB, HB, 6'h3F);
        check("R6 first frame only aligns", n_err, 0);

        for (int k = 0; k < 40; k++) begin
            logic [W-1:0] l, r;
            int nl, nr;
            case (k)
                0: begin l = 18'h1FFFF; r = 18'h20000; end
                1: begin l = 18'h00000; r = 18'h3FFFF; end
                2: begin l = 18'h3FFFF; r = 18'h00000; end
                default: begin
                    l = W'((k * 37 + 1) * 2311);
                    r = W'(~((k * 53 + 7) * 4099));
                end
            endcase
            nl = HB; nr = HB;
            if (k == 10) nl = 23;            // R5 short left
            if (k == 15) nr = 25;            // R5 long right
            if (k == 20) begin nl = 25; nr = 23; end
            if (k == 25) nr = 22;
            run_frame(l, r, nl, nr, k * 11);
        end
        run_frame(18'h0F0F0, 18'h30303, HB, HB, 0);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule